// File: doc/BRIEF.md
# Time-Windowed Preemptive Memory Arbiter

This block merges multi-beat memory commands from two requester classes, a general processor class (CPU) and a hard real-time transfer class (DMA), into a single beat stream that feeds a memory arbitration buffer. Time is cut into windows that alternate between the two classes. Each window favours one class and lasts a programmable number of cycles. When the favoured class has nothing to send, the other class may use the cycles, so no cycle is wasted.

A command that has started delivering beats normally runs to completion. Each class has a 2-bit preemption mode that decides when its in-flight command may be cut at a beat boundary by a command of the opposite class, during the opposite class's window. An interrupted command keeps its remaining beat count. It resumes where it stopped when its class is next granted. A command is never interrupted by a command of its own class.

A small word-wide register port sets the two window lengths and the two preemption modes. The output carries one beat per cycle with a class tag and a last-beat marker. The memory controller and the buffer itself sit outside this block.

Top module: `tw_arb`

## Requirements
- R1: After reset, both window-length fields read 0x003F, the mode register reads 0x0001_0001, and the first window is a CPU window lasting 64 cycles.
- R2: Windows alternate CPU, DMA, CPU, and so on. Each lasts its length field plus one cycles. A write to a length field takes effect the next time a window of that class begins, never in the window already running.
- R3: Register addresses are fixed: 0 holds the DMA window length in bits 15:0, 1 holds the CPU window length in bits 15:0, and 2 holds the modes, with the CPU mode in bits 17:16 and the DMA mode in bits 1:0. All other bits, and the whole of address 3, read as zero and ignore writes.
- R4: At most one beat leaves per cycle. `out_cls` is 0 for CPU and 1 for DMA. A class's ready is high only in a cycle where that class is granted while its valid is high. When no command is locked in, the favoured class of the current window is granted if it is valid, and otherwise the other class is granted.
- R5: A command has `beats` + 1 beats, with `beats` sampled on its first beat. `out_last` is high exactly on its final beat. An interrupted command still delivers exactly that many beats in total.
- R6: With mode 0 or mode 2, a class's command that has delivered its first beat keeps the grant on every following cycle in which its valid is high, until its last beat.
- R7: With mode 1, a class's in-flight command is interrupted only if its first beat went out during a window of the opposite class, that same window is still running, and the opposite class is valid.
- R8: With mode 3, a class's in-flight command is interrupted in any cycle of the opposite class's window in which the opposite class is valid, whenever the command started.
- R9: Only the opposite class ever takes the grant from an in-flight command. After an interruption, the interrupted command continues when arbitration next grants its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU command pending; held high until its last beat is accepted |
| cpu_beats | input | BEAT_W | CPU command length minus one, held while valid |
| cpu_ready | output | 1 | A CPU beat is accepted this cycle |
| dma_valid | input | 1 | DMA command pending; held high until its last beat is accepted |
| dma_beats | input | BEAT_W | DMA command length minus one, held while valid |
| dma_ready | output | 1 | A DMA beat is accepted this cycle |
| out_valid | output | 1 | A beat leaves toward the buffer this cycle |
| out_cls | output | 1 | Class of the outgoing beat (0 CPU, 1 DMA) |
| out_last | output | 1 | Outgoing beat is the final beat of its command |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |

## Verification
The hardest case to reach is the mode 1 interruption. A command must have started inside the opposite class's window while that class was idle, and the opposite class must then raise a request before the same window closes. Near-misses also matter: a command that started one window earlier must not be interrupted. The bench gets there by sweeping all sixteen pairs of modes over short windows of several lengths. Each class generates commands whose lengths and idle gaps come from arithmetic sequences, so starts land in every phase of both windows. A cycle-by-cycle expectation built from the requirements checks every grant. Separate counts of observed interruptions, grouped by the victim's mode, confirm that modes 1 and 3 did interrupt and that modes 0 and 2 never did.

// File: rtl/tw_arb_pkg.sv
package tw_arb_pkg;

    typedef enum logic {
        CLS_CPU = 1'b0,
        CLS_DMA = 1'b1
    } cls_e;

    typedef enum logic [1:0] {
        MODE_HOLD     = 2'd0,
        MODE_SAME_WIN = 2'd1,
        MODE_RSVD     = 2'd2,
        MODE_ANY_WIN  = 2'd3
    } pmode_e;

    localparam int NCLS         = 2;
    localparam int CPU_IDX      = 0;
    localparam int DMA_IDX      = 1;
    localparam int REG_AW       = 2;
    localparam int REG_DW       = 32;
    localparam int CPU_MODE_LSB = 16;
    localparam int DMA_MODE_LSB = 0;

    localparam logic [REG_AW-1:0] ADDR_DMA_WIN = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CPU_WIN = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_MODES   = 2'd2;

    function automatic cls_e other_cls(input cls_e c);
        return (c == CLS_CPU) ? CLS_DMA : CLS_CPU;
    endfunction

endpackage

// File: rtl/tw_arb_regs.sv
module tw_arb_regs
    import tw_arb_pkg::*;
#(
    parameter int unsigned      WIN_W    = 16,
    parameter logic [WIN_W-1:0] WIN_RST  = 'h3F,
    parameter logic [1:0]       MODE_RST = 2'd1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [REG_AW-1:0]           addr,
    input  logic [REG_DW-1:0]           wdata,
    output logic [REG_DW-1:0]           rdata,
    output logic [NCLS-1:0][WIN_W-1:0]  win_size,
    output logic [NCLS-1:0][1:0]        mode
);

    typedef struct packed {
        logic [NCLS-1:0][WIN_W-1:0] size;
        logic [NCLS-1:0][1:0]       mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                ADDR_DMA_WIN: r_d.size[DMA_IDX] = wdata[WIN_W-1:0];
                ADDR_CPU_WIN: r_d.size[CPU_IDX] = wdata[WIN_W-1:0];
                ADDR_MODES: begin
                    r_d.mode[CPU_IDX] = wdata[CPU_MODE_LSB +: 2];
                    r_d.mode[DMA_IDX] = wdata[DMA_MODE_LSB +: 2];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_DMA_WIN: rdata[WIN_W-1:0] = r_q.size[DMA_IDX];
            ADDR_CPU_WIN: rdata[WIN_W-1:0] = r_q.size[CPU_IDX];
            ADDR_MODES: begin
                rdata[CPU_MODE_LSB +: 2] = r_q.mode[CPU_IDX];
                rdata[DMA_MODE_LSB +: 2] = r_q.mode[DMA_IDX];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.size <= {NCLS{WIN_RST}};
            r_q.mode <= {NCLS{MODE_RST}};
        end else begin
            r_q <= r_d;
        end
    end

    assign win_size = r_q.size;
    assign mode     = r_q.mode;

endmodule

// File: rtl/tw_arb_window.sv
module tw_arb_window
    import tw_arb_pkg::*;
#(
    parameter int unsigned      WIN_W   = 16,
    parameter logic [WIN_W-1:0] WIN_RST = 'h3F
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCLS-1:0][WIN_W-1:0] win_size,
    output cls_e                       win_cls,
    output logic                       win_end
);

    typedef struct packed {
        cls_e             win;
        logic [WIN_W-1:0] cnt;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d     = w_q;
        win_end = (w_q.cnt == '0);
        if (win_end) begin
            w_d.win = other_cls(w_q.win);
            w_d.cnt = win_size[w_d.win];
        end else begin
            w_d.cnt = w_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.win <= CLS_CPU;
            w_q.cnt <= WIN_RST;
        end else begin
            w_q <= w_d;
        end
    end

    assign win_cls = w_q.win;

endmodule

// File: rtl/tw_arb_sched.sv
module tw_arb_sched
    import tw_arb_pkg::*;
#(
    parameter int unsigned BEAT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCLS-1:0]             valid,
    input  logic [NCLS-1:0][BEAT_W-1:0] beats,
    input  logic [NCLS-1:0][1:0]        mode,
    input  cls_e                        win_cls,
    input  logic                        win_end,
    output logic [NCLS-1:0]             ready,
    output logic                        out_valid,
    output cls_e                        out_cls,
    output logic                        out_last
);

    typedef struct packed {
        logic [NCLS-1:0][BEAT_W-1:0] rem;
        logic [NCLS-1:0]             flag;
        cls_e                        cur;
    } sched_t;

    sched_t s_d, s_q;

    logic [NCLS-1:0] cut;
    logic            busy;
    logic            gnt_v;
    cls_e            gnt_c;
    logic            last;

    always_comb begin
        for (int i = 0; i < NCLS; i++) begin
            cut[i] = (int'(win_cls) != i) && valid[NCLS-1-i] &&
                     ((mode[i] == MODE_ANY_WIN) ||
                      ((mode[i] == MODE_SAME_WIN) && s_q.flag[i]));
        end

        busy = (s_q.rem[s_q.cur] != '0);
        if (busy && !cut[s_q.cur]) begin
            gnt_v = valid[s_q.cur];
            gnt_c = s_q.cur;
        end else if (busy) begin
            gnt_v = 1'b1;
            gnt_c = other_cls(s_q.cur);
        end else if (valid[win_cls]) begin
            gnt_v = 1'b1;
            gnt_c = win_cls;
        end else begin
            gnt_v = valid[other_cls(win_cls)];
            gnt_c = other_cls(win_cls);
        end

        s_d  = s_q;
        last = 1'b0;
        if (gnt_v) begin
            s_d.cur = gnt_c;
            if (s_q.rem[gnt_c] == '0) begin
                s_d.rem[gnt_c]  = beats[gnt_c];
                s_d.flag[gnt_c] = (gnt_c != win_cls);
                last            = (beats[gnt_c] == '0);
            end else begin
                s_d.rem[gnt_c]  = s_q.rem[gnt_c] - 1'b1;
                last            = (s_q.rem[gnt_c] == BEAT_W'(1));
            end
        end
        if (win_end) begin
            s_d.flag = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.rem  <= '0;
            s_q.flag <= '0;
            s_q.cur  <= CLS_CPU;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NCLS; g++) begin : g_ready
        assign ready[g] = gnt_v && (int'(gnt_c) == g);
    end

    assign out_valid = gnt_v;
    assign out_cls   = gnt_c;
    assign out_last  = gnt_v && last;

endmodule

// File: rtl/tw_arb.sv
module tw_arb
    import tw_arb_pkg::*;
#(
    parameter int unsigned      WIN_W    = 16,
    parameter int unsigned      BEAT_W   = 4,
    parameter logic [WIN_W-1:0] WIN_RST  = 'h3F,
    parameter logic [1:0]       MODE_RST = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [BEAT_W-1:0] cpu_beats,
    output logic              cpu_ready,
    input  logic              dma_valid,
    input  logic [BEAT_W-1:0] dma_beats,
    output logic              dma_ready,
    output logic              out_valid,
    output logic              out_cls,
    output logic              out_last,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic [NCLS-1:0][WIN_W-1:0]  win_size;
    logic [NCLS-1:0][1:0]        mode_w;
    logic [NCLS-1:0]             valid_w;
    logic [NCLS-1:0]             ready_w;
    logic [NCLS-1:0][BEAT_W-1:0] beats_w;
    cls_e                        win_cls;
    logic                        win_end;
    cls_e                        cls_w;

    assign valid_w[CPU_IDX] = cpu_valid;
    assign valid_w[DMA_IDX] = dma_valid;
    assign beats_w[CPU_IDX] = cpu_beats;
    assign beats_w[DMA_IDX] = dma_beats;
    assign cpu_ready        = ready_w[CPU_IDX];
    assign dma_ready        = ready_w[DMA_IDX];
    assign out_cls          = cls_w;

    tw_arb_regs #(
        .WIN_W    (WIN_W),
        .WIN_RST  (WIN_RST),
        .MODE_RST (MODE_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .win_size (win_size),
        .mode     (mode_w)
    );

    tw_arb_window #(
        .WIN_W   (WIN_W),
        .WIN_RST (WIN_RST)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_size (win_size),
        .win_cls  (win_cls),
        .win_end  (win_end)
    );

    tw_arb_sched #(
        .BEAT_W (BEAT_W)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (valid_w),
        .beats     (beats_w),
        .mode      (mode_w),
        .win_cls   (win_cls),
        .win_end   (win_end),
        .ready     (ready_w),
        .out_valid (out_valid),
        .out_cls   (cls_w),
        .out_last  (out_last)
    );

endmodule

// File: rtl/tw_arb_chk.sv
module tw_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_valid,
    input logic       cpu_ready,
    input logic       dma_valid,
    input logic       dma_ready,
    input logic       out_valid,
    input logic       out_last,
    input logic       reg_we,
    input logic [1:0] mode_cpu,
    input logic [1:0] mode_dma,
    input logic       win_cls,
    input logic       win_end
);

    assert_win_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (win_cls != $past(win_cls)));

    assert_win_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(win_cls));

    assert_one_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({cpu_ready, dma_ready}) == 1));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(cpu_ready || dma_ready));

    assert_cpu_ready_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    assert_dma_ready_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ready |-> dma_valid);

    assert_last_in_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_cpu_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !out_last && !mode_cpu[0] && !reg_we) |=> (!cpu_valid || cpu_ready));

    assert_dma_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ready && !out_last && !mode_dma[0] && !reg_we) |=> (!dma_valid || dma_ready));

endmodule

bind tw_arb tw_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .dma_valid (dma_valid),
    .dma_ready (dma_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .reg_we    (reg_we),
    .mode_cpu  (mode_w[0]),
    .mode_dma  (mode_w[1]),
    .win_cls   (win_cls),
    .win_end   (win_end)
);

// File: tb/tw_arb_tb.sv
module tw_arb_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BEAT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0, dma_valid = 1'b0;
    logic [BEAT_W-1:0] cpu_beats = '0, dma_beats = '0;
    logic              cpu_ready, dma_ready, out_valid, out_cls, out_last;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    always #2.5 clk = ~clk;

    tw_arb u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_beats(cpu_beats), .cpu_ready(cpu_ready),
        .dma_valid(dma_valid), .dma_beats(dma_beats), .dma_ready(dma_ready),
        .out_valid(out_valid), .out_cls(out_cls), .out_last(out_last),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    int checks = 0;
    int errors = 0;

    // expectation state built from the requirements
    int m_win, m_cnt, m_cur;
    int m_rem[2];
    bit m_flag[2];
    int sz[2];
    int md[2];

    // requester state
    bit te;
    int seed;
    bit rq_on[2];
    int rq_len[2], rq_sent[2], rq_gap[2], rq_k[2];
    int intr[4];

    function automatic int len_of(int i, int k);
        return 1 + ((k * 5 + i * 3 + seed) % 8);
    endfunction

    function automatic int gap_of(int i, int k);
        return (k * 3 + i + seed) % 5;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        reg_we = 1'b0;
        te = 1'b0;
        for (int i = 0; i < 2; i++) begin
            rq_on[i] = 1'b0; rq_len[i] = 1; rq_sent[i] = 0; rq_gap[i] = 0; rq_k[i] = 0;
            m_rem[i] = 0; m_flag[i] = 1'b0; sz[i] = 63; md[i] = 1;
        end
        cpu_valid = 1'b0; dma_valid = 1'b0; cpu_beats = '0; dma_beats = '0;
        m_win = 0; m_cnt = 63; m_cur = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic step();
        bit vin[2];
        int bin[2];
        bit cut[2];
        bit ev, el, busy, gr[2];
        int ec;
        @(negedge clk);
        vin[0] = cpu_valid; vin[1] = dma_valid;
        bin[0] = int'(cpu_beats); bin[1] = int'(dma_beats);
        for (int i = 0; i < 2; i++)
            cut[i] = (m_win != i) && vin[1-i] && (md[i] == 3 || (md[i] == 1 && m_flag[i]));
        busy = (m_rem[m_cur] != 0);
        if (busy && !cut[m_cur]) begin ev = vin[m_cur]; ec = m_cur; end
        else if (busy) begin ev = 1'b1; ec = 1 - m_cur; end
        else if (vin[m_win]) begin ev = 1'b1; ec = m_win; end
        else begin ev = vin[1-m_win]; ec = 1 - m_win; end
        el = ev && ((m_rem[ec] == 0) ? (bin[ec] == 0) : (m_rem[ec] == 1));

        checks++;
        if (out_valid !== ev || (ev && (out_cls !== ec[0] || out_last !== el)) ||
            cpu_ready !== (ev && ec == 0) || dma_ready !== (ev && ec == 1)) begin
            errors++;
            $display("FAIL R1 R2 R4 R6 R7 R8 R9 grant at %0t: got v=%0b c=%0b l=%0b rdy=%0b%0b expected v=%0b c=%0d l=%0b",
                     $time, out_valid, out_cls, out_last, cpu_ready, dma_ready, ev, ec, el);
        end

        // R5 beat count seen from the requester side
        gr[0] = cpu_ready; gr[1] = dma_ready;
        for (int i = 0; i < 2; i++) begin
            if (gr[i] && rq_on[i]) begin
                checks++;
                if (out_last !== (rq_sent[i] + 1 == rq_len[i])) begin
                    errors++;
                    $display("FAIL R5 class %0d last marker: got %0b expected %0b (beat %0d of %0d)",
                             i, out_last, (rq_sent[i] + 1 == rq_len[i]), rq_sent[i] + 1, rq_len[i]);
                end
            end
            if (rq_on[i] && rq_sent[i] > 0 && gr[1-i]) intr[md[i]]++;
        end

        // expectation update at the edge
        if (ev) begin
            if (m_rem[ec] == 0) begin
                m_rem[ec] = bin[ec];
                m_flag[ec] = (m_win != ec);
            end else begin
                m_rem[ec] = m_rem[ec] - 1;
            end
            m_cur = ec;
        end
        if (m_cnt == 0) begin
            m_win = 1 - m_win;
            m_cnt = sz[m_win];
            m_flag[0] = 1'b0; m_flag[1] = 1'b0;
        end else begin
            m_cnt = m_cnt - 1;
        end
        if (reg_we) begin
            case (reg_addr)
                2'd0: sz[1] = int'(reg_wdata[15:0]);
                2'd1: sz[0] = int'(reg_wdata[15:0]);
                2'd2: begin md[0] = int'(reg_wdata[17:16]); md[1] = int'(reg_wdata[1:0]); end
                default: ;
            endcase
        end

        // requester update
        for (int i = 0; i < 2; i++) begin
            if (rq_on[i]) begin
                if (gr[i]) begin
                    rq_sent[i]++;
                    if (rq_sent[i] == rq_len[i]) begin
                        rq_on[i] = 1'b0;
                        rq_gap[i] = gap_of(i, rq_k[i]);
                        rq_k[i]++;
                    end
                end
            end else if (te) begin
                if (rq_gap[i] > 0) rq_gap[i]--;
                else begin
                    rq_on[i] = 1'b1;
                    rq_len[i] = len_of(i, rq_k[i]);
                    rq_sent[i] = 0;
                end
            end
        end

        @(posedge clk);
        #1;
        reg_we = 1'b0;
        cpu_valid = rq_on[0];
        dma_valid = rq_on[1];
        cpu_beats = rq_on[0] ? BEAT_W'(rq_len[0] - 1) : '0;
        dma_beats = rq_on[1] ? BEAT_W'(rq_len[1] - 1) : '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        step();
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #0.2;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: got %08h expected %08h", tag, a, reg_rdata, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) intr[i] = 0;

        // R1 reset values
        do_reset();
        checks++;
        if (out_valid !== 1'b0 || cpu_ready !== 1'b0 || dma_ready !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle after reset: got v=%0b expected 0", out_valid);
        end
        rd_check(2'd0, 32'h0000_003F, "R1");
        rd_check(2'd1, 32'h0000_003F, "R1");
        rd_check(2'd2, 32'h0001_0001, "R1");

        // R3 unused bits and address 3
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd_check(2'd0, 32'h0000_FFFF, "R3");
        rd_check(2'd1, 32'h0000_FFFF, "R3");
        rd_check(2'd2, 32'h0003_0003, "R3");
        rd_check(2'd3, 32'h0000_0000, "R3");
        wr(2'd2, 32'h0002_0000);
        rd_check(2'd2, 32'h0002_0000, "R3");

        // sweep of all mode pairs over short windows (R1 R2 R4..R9)
        for (int cm = 0; cm < 4; cm++) begin
            for (int dm = 0; dm < 4; dm++) begin
                for (int cfg = 0; cfg < 2; cfg++) begin
                    do_reset();
                    seed = cm * 8 + dm * 2 + cfg;
                    wr(2'd1, (cfg == 0) ? 32'd5 : 32'd2);
                    wr(2'd0, (cfg == 0) ? 32'd3 : 32'd7);
                    wr(2'd2, (32'(cm) << 16) | 32'(dm));
                    te = 1'b1;
                    repeat (350) step();
                    wr(2'd1, (cfg == 0) ? 32'd9 : 32'd1);
                    repeat (350) step();
                    te = 1'b0;
                end
            end
        end

        // interruption coverage by victim mode
        checks++;
        if (intr[0] != 0 || intr[2] != 0) begin
            errors++;
            $display("FAIL R6 interruptions under mode 0/2: got %0d/%0d expected 0/0", intr[0], intr[2]);
        end
        checks++;
        if (intr[1] == 0) begin
            errors++;
            $display("FAIL R7 mode 1 interruptions: got 0 expected >0");
        end
        checks++;
        if (intr[3] == 0) begin
            errors++;
            $display("FAIL R8 mode 3 interruptions: got 0 expected >0");
        end
        checks++;
        if (intr[3] < intr[1]) begin
            errors++;
            $display("FAIL R8 R7 mode 3 count %0d expected at least mode 1 count %0d", intr[3], intr[1]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule